// File: doc/BRIEF.md
# Cyclic audio DMA channel

This block is a single DMA channel that moves 32-bit words between a ring buffer in memory and an audio peripheral FIFO, in either direction, and keeps looping over the ring until software turns it off. The ring holds one to eight periods of equal size. A completed-period counter and an end-of-period interrupt let software follow the channel's progress through the ring.

Software sets up the channel through a small register bus with combinational reads and single-cycle writes. It programs the ring base address, the period length in bytes, the number of periods, the burst length, the direction and the flow-control mode, then sets the run bit. The engine works one burst at a time and uses a one-word memory request port with a separate read-response strobe.

On the peripheral side there are two valid/ready streams. On the outgoing stream the channel holds `tx_valid` and `tx_data` steady until `tx_ready` is seen high. On the incoming stream it raises `rx_ready` only when it can take a word. The peripheral also reports its free space (`tx_space`) and its fill level (`rx_level`), and the channel uses these when flow control is enabled.

Top module: `ring_audio_dma`

Register word offsets on `reg_addr`: 0x00 run command, 0x04 status, 0x08 interrupt status, 0x0C interrupt clear, 0x10 control, 0x14 ring configuration, 0x18 memory-to-peripheral base, 0x1C peripheral-to-memory base, 0x20 period length in bytes, 0x24 completed-period count. Any other address, or a non-zero `reg_addr[1:0]`, reads as zero and ignores writes.

## Requirements
- R1: After reset every register reads 0. Status bit 0 (active) and bit 1 (paused) are 0, `irq` is low, and `mem_req_valid`, `tx_valid` and `rx_ready` are low.
- R2: Writing 1 to bit 0 of the run register starts an idle channel, but only if the control direction field (bits 7:4) holds 2 (peripheral to memory) or 4 (memory to peripheral). A start restarts the ring at period 0, word 0, and clears the completed-period count. With any other direction code the channel stays idle.
- R3: In memory-to-peripheral mode the channel reads memory at base + period index × period bytes + word offset × 4. It presents the words on the tx stream in ring order and wraps from the last period back to the first without stopping. While `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged.
- R4: In peripheral-to-memory mode each word accepted on the rx stream is written to the next ring location of the peripheral-to-memory base, in the same ring order and with the same wrap as R3.
- R5: Three fields set the ring layout. The period length is taken from bits 29:2 of the length register, as a word count, and 0 counts as 1. The number of periods is configuration bits 2:0 plus 1. The burst length is configuration bits 11:8 plus 1, from 1 to 16 words. A burst never crosses the end of a period, so the last burst of a period is shortened.
- R6: A memory request keeps its valid, address and write flag unchanged until `mem_req_ready` is seen high. Every request address is word aligned.
- R7: When control bit 1 (flow control) is set, a memory-to-peripheral burst starts only when `tx_space` is at least the burst length. Likewise, a peripheral-to-memory burst starts only when `rx_level` is at least the burst length. When the bit is clear, the channel ignores both levels.
- R8: Interrupt status bit 0 is set in the cycle after the last word of any period completes, and `irq` follows it. Writing 1 to bit 0 of the clear register clears it. A new period completion in the same cycle wins over the clear.
- R9: The completed-period count (low 16 bits of its register) goes up by one per completed period and wraps from 65535 to 0.
- R10: Setting control bit 0 (pause) lets the burst in flight finish. The channel then reports status bit 1 and issues no memory or stream traffic. Clearing the bit resumes at exactly the next word of the ring.
- R11: Writing 0 to the run bit lets the current burst drain. Status bit 0 then drops.
- R12: While the channel is not active, it raises none of `mem_req_valid`, `tx_valid` and `rx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte address |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Period-complete interrupt |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address, word aligned |
| mem_req_wdata | output | DATA_W | Write data |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | DATA_W | Read response data |
| tx_valid | output | 1 | Outgoing stream valid |
| tx_ready | input | 1 | Outgoing stream ready |
| tx_data | output | DATA_W | Outgoing stream word |
| tx_space | input | LVL_W | Free words in the peripheral FIFO |
| rx_valid | input | 1 | Incoming stream valid |
| rx_ready | output | 1 | Incoming stream ready |
| rx_data | input | DATA_W | Incoming stream word |
| rx_level | input | LVL_W | Words waiting in the peripheral FIFO |

## Verification
Assertions check several rules on every cycle. Memory requests and the outgoing stream word must hold steady under back-pressure, and request addresses must stay aligned. A paused or inactive channel must be quiet. The interrupt must follow each period end.

Only the bench scenarios can show the rest: that the ring order and wrap are correct, that short bursts land on period ends, and that pause resumes at the exact word. They also show that flow control holds bursts back, that the period count and the memory contents left by peripheral-to-memory traffic are right, and that a bad direction code never starts the channel.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
  localparam int REG_W = 32;

  localparam logic [3:0] DIR_P2M = 4'd2;
  localparam logic [3:0] DIR_M2P = 4'd4;

  localparam logic [3:0] IDX_RUN   = 4'h0;
  localparam logic [3:0] IDX_STAT  = 4'h1;
  localparam logic [3:0] IDX_ISTAT = 4'h2;
  localparam logic [3:0] IDX_ICLR  = 4'h3;
  localparam logic [3:0] IDX_CTRL  = 4'h4;
  localparam logic [3:0] IDX_CFG   = 4'h5;
  localparam logic [3:0] IDX_SRC   = 4'h6;
  localparam logic [3:0] IDX_DST   = 4'h7;
  localparam logic [3:0] IDX_LEN   = 4'h8;
  localparam logic [3:0] IDX_DONE  = 4'h9;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_TX_SEND,
    ST_RX_WAIT,
    ST_WR_REQ,
    ST_PAUSED
  } eng_state_t;
endpackage

// File: rtl/rdma_regs.sv
module rdma_regs
  import ring_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PER_W  = 28,
  parameter int RING_W = 3,
  parameter int BM1_W  = 4,
  parameter int DONE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        reg_addr,
  input  logic              reg_wen,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              active,
  input  logic              paused,
  input  logic              period_end,
  input  logic [DONE_W-1:0] done_cnt,
  output logic              run_req,
  output logic              pause_req,
  output logic              flow_en,
  output logic [3:0]        dir_code,
  output logic [RING_W-1:0] last_period,
  output logic [BM1_W-1:0]  burst_m1,
  output logic [ADDR_W-1:0] src_base,
  output logic [ADDR_W-1:0] dst_base,
  output logic [PER_W-1:0]  period_words,
  output logic              irq
);
  logic       hit;
  logic [3:0] idx;
  logic       wr;

  // Full decode: two upper bits and the byte-lane bits must be zero
  assign hit = (reg_addr[7:6] == 2'b00) && (reg_addr[1:0] == 2'b00);
  assign idx = reg_addr[5:2];
  assign wr  = reg_wen && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_req      <= 1'b0;
      pause_req    <= 1'b0;
      flow_en      <= 1'b0;
      dir_code     <= '0;
      last_period  <= '0;
      burst_m1     <= '0;
      src_base     <= '0;
      dst_base     <= '0;
      period_words <= '0;
      irq          <= 1'b0;
    end else begin
      if (wr) begin
        case (idx)
          IDX_RUN:  run_req <= reg_wdata[0];
          IDX_CTRL: begin
            pause_req <= reg_wdata[0];
            flow_en   <= reg_wdata[1];
            dir_code  <= reg_wdata[7:4];
          end
          IDX_CFG: begin
            last_period <= reg_wdata[RING_W-1:0];
            burst_m1    <= reg_wdata[8 +: BM1_W];
          end
          IDX_SRC:  src_base     <= {reg_wdata[ADDR_W-1:2], 2'b00};
          IDX_DST:  dst_base     <= {reg_wdata[ADDR_W-1:2], 2'b00};
          IDX_LEN:  period_words <= reg_wdata[2 +: PER_W];
          default: ;
        endcase
      end
      // completion outranks a simultaneous clear
      if (period_end) irq <= 1'b1;
      else if (wr && idx == IDX_ICLR && reg_wdata[0]) irq <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit) begin
      case (idx)
        IDX_RUN:   reg_rdata[0] = run_req;
        IDX_STAT:  reg_rdata[1:0] = {paused, active};
        IDX_ISTAT: reg_rdata[0] = irq;
        IDX_CTRL:  reg_rdata[7:0] = {dir_code, 2'b00, flow_en, pause_req};
        IDX_CFG: begin
          reg_rdata[RING_W-1:0] = last_period;
          reg_rdata[8 +: BM1_W] = burst_m1;
        end
        IDX_SRC:   reg_rdata[ADDR_W-1:0] = src_base;
        IDX_DST:   reg_rdata[ADDR_W-1:0] = dst_base;
        IDX_LEN:   reg_rdata[2 +: PER_W] = period_words;
        IDX_DONE:  reg_rdata[DONE_W-1:0] = done_cnt;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rdma_ring_walker.sv
module rdma_ring_walker #(
  parameter int ADDR_W = 32,
  parameter int PER_W  = 28,
  parameter int RING_W = 3,
  parameter int BM1_W  = 4,
  parameter int DONE_W = 16,
  localparam int BLEN_W = BM1_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  input  logic [PER_W-1:0]  period_words,
  input  logic [RING_W-1:0] last_period,
  input  logic [BM1_W-1:0]  burst_m1,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [BLEN_W-1:0] blen,
  output logic              period_end,
  output logic [DONE_W-1:0] done_cnt
);
  logic [PER_W-1:0]  pw_eff;
  logic [PER_W-1:0]  word_off;
  logic [PER_W-1:0]  rem;
  logic [RING_W-1:0] per_idx;
  logic [ADDR_W-1:0] per_off;
  logic [BLEN_W-1:0] burst_words;
  logic              last_word;

  assign pw_eff      = (period_words == '0) ? PER_W'(1) : period_words;
  assign rem         = pw_eff - word_off;
  assign burst_words = BLEN_W'(burst_m1) + BLEN_W'(1);
  // shorten the burst so it stops on the period boundary
  assign blen        = (rem < PER_W'(burst_words)) ? rem[BLEN_W-1:0] : burst_words;
  assign last_word   = (word_off == pw_eff - PER_W'(1));
  assign period_end  = step && last_word;
  assign cur_addr    = base + per_off + (ADDR_W'(word_off) << 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_off <= '0;
      per_idx  <= '0;
      per_off  <= '0;
      done_cnt <= '0;
    end else if (restart) begin
      word_off <= '0;
      per_idx  <= '0;
      per_off  <= '0;
      done_cnt <= '0;
    end else if (step) begin
      if (last_word) begin
        word_off <= '0;
        done_cnt <= done_cnt + DONE_W'(1);
        if (per_idx >= last_period) begin
          per_idx <= '0;
          per_off <= '0;
        end else begin
          per_idx <= per_idx + RING_W'(1);
          per_off <= per_off + (ADDR_W'(pw_eff) << 2);
        end
      end else begin
        word_off <= word_off + PER_W'(1);
      end
    end
  end
endmodule

// File: rtl/rdma_burst_engine.sv
module rdma_burst_engine
  import ring_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BLEN_W = 5,
  parameter int LVL_W  = 5,
  localparam int CMP_W = (LVL_W > BLEN_W) ? LVL_W : BLEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_req,
  input  logic              pause_req,
  input  logic              flow_en,
  input  logic [3:0]        dir_code,
  input  logic [BLEN_W-1:0] blen,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic              restart,
  output logic              step,
  output logic              active,
  output logic              paused,
  output logic              m2p,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic [LVL_W-1:0]  tx_space,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [LVL_W-1:0]  rx_level
);
  eng_state_t        st;
  logic [BLEN_W-1:0] left;
  logic [DATA_W-1:0] hold;
  logic              dir_ok;
  logic              room_ok;
  logic [LVL_W-1:0]  lvl;

  assign dir_ok  = (dir_code == DIR_P2M) || (dir_code == DIR_M2P);
  assign lvl     = m2p ? tx_space : rx_level;
  assign room_ok = !flow_en || (CMP_W'(lvl) >= CMP_W'(blen));
  assign restart = (st == ST_IDLE) && run_req && dir_ok;

  assign mem_req_valid = (st == ST_RD_REQ) || (st == ST_WR_REQ);
  assign mem_req_write = (st == ST_WR_REQ);
  assign mem_req_addr  = cur_addr;
  assign mem_req_wdata = hold;
  assign tx_valid      = (st == ST_TX_SEND);
  assign tx_data       = hold;
  assign rx_ready      = (st == ST_RX_WAIT);
  assign active        = (st != ST_IDLE);
  assign paused        = (st == ST_PAUSED);
  assign step          = ((st == ST_TX_SEND) && tx_ready) ||
                         ((st == ST_WR_REQ) && mem_req_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      left <= '0;
      hold <= '0;
      m2p  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (restart) begin
          m2p <= (dir_code == DIR_M2P);
          st  <= ST_ARM;
        end
        ST_ARM: begin
          if (!run_req)      st <= ST_IDLE;
          else if (pause_req) st <= ST_PAUSED;
          else if (room_ok) begin
            left <= blen;
            st   <= m2p ? ST_RD_REQ : ST_RX_WAIT;
          end
        end
        ST_RD_REQ:  if (mem_req_ready) st <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rsp_valid) begin
          hold <= mem_rsp_data;
          st   <= ST_TX_SEND;
        end
        ST_TX_SEND: if (tx_ready) begin
          left <= left - BLEN_W'(1);
          st   <= (left == BLEN_W'(1)) ? ST_ARM : ST_RD_REQ;
        end
        ST_RX_WAIT: if (rx_valid) begin
          hold <= rx_data;
          st   <= ST_WR_REQ;
        end
        ST_WR_REQ: if (mem_req_ready) begin
          left <= left - BLEN_W'(1);
          st   <= (left == BLEN_W'(1)) ? ST_ARM : ST_RX_WAIT;
        end
        ST_PAUSED: begin
          if (!run_req)        st <= ST_IDLE;
          else if (!pause_req) st <= ST_ARM;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_audio_dma.sv
module ring_audio_dma
  import ring_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PER_W  = 28,
  parameter int RING_W = 3,
  parameter int BM1_W  = 4,
  parameter int LVL_W  = 5,
  parameter int DONE_W = 16,
  localparam int BLEN_W = BM1_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        reg_addr,
  input  logic              reg_wen,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic [LVL_W-1:0]  tx_space,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [LVL_W-1:0]  rx_level
);
  logic              run_req, pause_req, flow_en;
  logic [3:0]        dir_code;
  logic [RING_W-1:0] last_period;
  logic [BM1_W-1:0]  burst_m1;
  logic [ADDR_W-1:0] src_base, dst_base, ring_base, cur_addr;
  logic [PER_W-1:0]  period_words;
  logic [BLEN_W-1:0] blen;
  logic              restart, step, eng_active, eng_paused, eng_m2p, period_end;
  logic [DONE_W-1:0] done_cnt;

  // memory side of the ring follows the direction latched at start
  assign ring_base = eng_m2p ? src_base : dst_base;

  rdma_regs #(
    .ADDR_W(ADDR_W), .PER_W(PER_W), .RING_W(RING_W),
    .BM1_W(BM1_W), .DONE_W(DONE_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .active(eng_active), .paused(eng_paused),
    .period_end(period_end), .done_cnt(done_cnt),
    .run_req(run_req), .pause_req(pause_req), .flow_en(flow_en),
    .dir_code(dir_code), .last_period(last_period), .burst_m1(burst_m1),
    .src_base(src_base), .dst_base(dst_base), .period_words(period_words),
    .irq(irq)
  );

  rdma_ring_walker #(
    .ADDR_W(ADDR_W), .PER_W(PER_W), .RING_W(RING_W),
    .BM1_W(BM1_W), .DONE_W(DONE_W)
  ) u_walk (
    .clk(clk), .rst_n(rst_n),
    .restart(restart), .step(step),
    .base(ring_base), .period_words(period_words),
    .last_period(last_period), .burst_m1(burst_m1),
    .cur_addr(cur_addr), .blen(blen),
    .period_end(period_end), .done_cnt(done_cnt)
  );

  rdma_burst_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLEN_W(BLEN_W), .LVL_W(LVL_W)
  ) u_eng (
    .clk(clk), .rst_n(rst_n),
    .run_req(run_req), .pause_req(pause_req), .flow_en(flow_en),
    .dir_code(dir_code), .blen(blen), .cur_addr(cur_addr),
    .restart(restart), .step(step),
    .active(eng_active), .paused(eng_paused), .m2p(eng_m2p),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_space(tx_space),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_level(rx_level)
  );
endmodule

// File: rtl/ring_audio_dma_chk.sv
module ring_audio_dma_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] tx_data,
  input logic              rx_ready,
  input logic              active,
  input logic              paused,
  input logic              period_end,
  input logic              irq
);
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  assert_req_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  assert_pause_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> (!mem_req_valid && !tx_valid && !rx_ready));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!mem_req_valid && !tx_valid && !rx_ready));

  assert_irq_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> irq);
endmodule

bind ring_audio_dma ring_audio_dma_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .rx_ready(rx_ready), .active(eng_active), .paused(eng_paused),
  .period_end(period_end), .irq(irq)
);

// File: tb/ring_audio_dma_test.sv
`timescale 1ns/1ps
module ring_audio_dma_test;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LVL_W  = 5;

  localparam logic [7:0] A_RUN = 8'h00, A_STAT = 8'h04, A_ISTAT = 8'h08,
    A_ICLR = 8'h0C, A_CTRL = 8'h10, A_CFG = 8'h14, A_SRC = 8'h18,
    A_DST = 8'h1C, A_LEN = 8'h20, A_DONE = 8'h24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] reg_addr = '0;
  logic reg_wen = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;
  logic mem_req_valid, mem_req_write;
  logic mem_req_ready = 1'b0;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [DATA_W-1:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [DATA_W-1:0] mem_rsp_data = '0;
  logic tx_valid;
  logic tx_ready = 1'b0;
  logic [DATA_W-1:0] tx_data;
  logic [LVL_W-1:0] tx_space = 5'd16;
  logic rx_valid = 1'b0;
  logic rx_ready;
  logic [DATA_W-1:0] rx_data = '0;
  logic [LVL_W-1:0] rx_level = 5'd16;

  int vec_cnt = 0;
  int fail_cnt = 0;
  bit finished = 1'b0;

  logic [31:0] mem [0:255];
  int tx_cnt = 0;
  int rd_cnt = 0;
  int rx_idx = 0;
  bit exp_on = 1'b0;
  int exp_base = 0;
  int exp_ring = 1;
  int rsp_lat = 0;
  logic [31:0] rsp_word = '0;

  always #10 clk = ~clk;

  ring_audio_dma uut (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_space(tx_space),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_level(rx_level)
  );

  function automatic logic [31:0] init_word(input int i);
    return 32'h5A00_0000 + 32'(i) * 32'h0001_0003;
  endfunction

  function automatic logic [31:0] exp_tx(input int k);
    return init_word(exp_base + (k % exp_ring));
  endfunction

  function automatic logic [31:0] rx_word(input int k);
    return 32'hC0DE_0000 + 32'(k);
  endfunction

  function automatic logic [31:0] ctrl_val(input logic [3:0] d, input bit fl, input bit ps);
    return {24'b0, d, 2'b00, fl, ps};
  endfunction

  function automatic logic [31:0] cfg_val(input int nper, input int burst);
    logic [31:0] v;
    v = '0;
    v[2:0]  = 3'(nper - 1);
    v[11:8] = 4'(burst - 1);
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    vec_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #2 d = reg_rdata;
  endtask

  task automatic wait_tx(input int n);
    while (tx_cnt < n) @(negedge clk);
  endtask

  task automatic stop_chan(input string tag);
    logic [31:0] d;
    int t0, r0;
    wr(A_RUN, 32'd0);
    d = 32'd1;
    for (int i = 0; i < 300; i++) begin
      rd(A_STAT, d);
      if (d[0] == 1'b0) break;
    end
    check(d[0] == 1'b0, "R11 active drops after drain", d, 32'd0);
    t0 = tx_cnt; r0 = rd_cnt;
    repeat (30) @(negedge clk);
    check(tx_cnt == t0 && rd_cnt == r0, tag, 32'(tx_cnt + rd_cnt), 32'(t0 + r0));
  endtask

  // memory, tx sink and rx source models, all acting at the falling edge
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = init_word(i);
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (rsp_lat > 0) begin
        rsp_lat--;
        if (rsp_lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rsp_word;
        end
      end
      mem_req_ready = ($urandom % 4) != 0;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) mem[mem_req_addr[9:2]] = mem_req_wdata;
        else begin
          rd_cnt++;
          rsp_word = mem[mem_req_addr[9:2]];
          rsp_lat  = 1 + int'($urandom % 3);
        end
      end
      tx_ready = ($urandom % 3) != 0;
      if (tx_valid && tx_ready) begin
        if (exp_on) check(tx_data == exp_tx(tx_cnt), "R3 ring word order", tx_data, exp_tx(tx_cnt));
        tx_cnt++;
      end
      rx_valid = ($urandom % 3) != 0;
      rx_data  = rx_word(rx_idx);
      if (rx_valid && rx_ready) rx_idx++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fail_cnt++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, fail_cnt);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int t0, r0, pw, np, bu, total, k;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_STAT, d);  check(d == 0, "R1 status after reset", d, 0);
    rd(A_RUN, d);   check(d == 0, "R1 run after reset", d, 0);
    rd(A_ISTAT, d); check(d == 0, "R1 irq status after reset", d, 0);
    rd(A_DONE, d);  check(d == 0, "R1 done count after reset", d, 0);
    check(!irq && !tx_valid && !mem_req_valid && !rx_ready, "R1 outputs idle",
          {29'b0, irq, tx_valid, mem_req_valid}, 0);

    // R2 bad direction code never starts
    wr(A_CTRL, ctrl_val(4'd3, 1'b0, 1'b0));
    wr(A_RUN, 32'd1);
    repeat (10) @(negedge clk);
    rd(A_STAT, d); check(d[0] == 1'b0, "R2 invalid direction stays idle", d, 0);
    check(rd_cnt == 0, "R12 no reads while idle", 32'(rd_cnt), 0);
    wr(A_RUN, 32'd0);

    // main memory-to-peripheral run: 3 periods of 3 words, burst 2
    exp_base = 16; exp_ring = 9; exp_on = 1'b1; tx_cnt = 0;
    wr(A_SRC, 32'h40); wr(A_LEN, 32'd12); wr(A_CFG, cfg_val(3, 2));
    wr(A_CTRL, ctrl_val(4'd4, 1'b0, 1'b0));
    wr(A_RUN, 32'd1);
    rd(A_STAT, d); check(d[0] == 1'b1, "R2 start sets active", d, 1);
    wait_tx(30);

    // R10 pause at a burst boundary
    wr(A_CTRL, ctrl_val(4'd4, 1'b0, 1'b1));
    d = 0;
    for (int i = 0; i < 300; i++) begin
      rd(A_STAT, d);
      if (d[1]) break;
    end
    check(d[1:0] == 2'b11, "R10 paused status", d, 3);
    t0 = tx_cnt; r0 = rd_cnt;
    repeat (40) @(negedge clk);
    check(tx_cnt == t0 && rd_cnt == r0, "R10 no traffic while paused", 32'(tx_cnt), 32'(t0));
    check((t0 % 3) != 1, "R5 burst shortened at period end", 32'(t0 % 3), 0);
    rd(A_DONE, d); check(d == 32'(t0 / 3), "R9 completed period count", d, 32'(t0 / 3));
    rd(A_ISTAT, d); check(d[0] && irq, "R8 period interrupt raised", d, 1);
    wr(A_ICLR, 32'd1);
    rd(A_ISTAT, d); check(d == 0 && !irq, "R8 write-one clear", d, 0);
    wr(A_CTRL, ctrl_val(4'd4, 1'b0, 1'b0));
    wait_tx(t0 + 10);
    check(tx_cnt >= t0 + 10, "R10 resume continues", 32'(tx_cnt), 32'(t0 + 10));
    stop_chan("R12 quiet after disable");

    // randomized ring shapes, burst up to 16 (may exceed period)
    for (int run = 0; run < 4; run++) begin
      pw = 1 + int'($urandom % 5);
      np = 1 + int'($urandom % 8);
      bu = (run == 0) ? 16 : 1 + int'($urandom % 16);
      exp_ring = pw * np;
      exp_base = int'($urandom % 80);
      tx_cnt = 0;
      wr(A_SRC, 32'(exp_base * 4)); wr(A_LEN, 32'(pw * 4)); wr(A_CFG, cfg_val(np, bu));
      wr(A_CTRL, ctrl_val(4'd4, 1'b0, 1'b0));
      wr(A_RUN, 32'd1);
      wait_tx(2 * exp_ring + 3);
      stop_chan("R11 quiet after random run");
      rd(A_DONE, d);
      check(d == 32'(tx_cnt / pw), "R9 count restarts and tracks periods", d, 32'(tx_cnt / pw));
      check((tx_cnt % pw) == 0 || (tx_cnt % pw) % bu == 0, "R5 bursts stay inside period",
            32'(tx_cnt % pw), 0);
    end

    // R7 flow control on the outgoing side
    exp_base = 4; exp_ring = 8; tx_cnt = 0; tx_space = 5'd2;
    r0 = rd_cnt;
    wr(A_SRC, 32'h10); wr(A_LEN, 32'd16); wr(A_CFG, cfg_val(2, 4));
    wr(A_CTRL, ctrl_val(4'd4, 1'b1, 1'b0));
    wr(A_RUN, 32'd1);
    repeat (40) @(negedge clk);
    check(tx_cnt == 0 && rd_cnt == r0, "R7 burst held for lack of room", 32'(tx_cnt), 0);
    tx_space = 5'd4;
    wait_tx(8);
    check(tx_cnt >= 8, "R7 burst runs once room is reported", 32'(tx_cnt), 8);
    stop_chan("R12 quiet after flow run");
    exp_on = 1'b0;

    // R4 peripheral-to-memory: 4 periods of 2 words, burst 2
    rx_level = 5'd1; rx_idx = 0;
    wr(A_DST, 32'h200); wr(A_LEN, 32'd8); wr(A_CFG, cfg_val(4, 2));
    wr(A_CTRL, ctrl_val(4'd2, 1'b1, 1'b0));
    wr(A_RUN, 32'd1);
    repeat (30) @(negedge clk);
    check(rx_idx == 0, "R7 rx burst held for low level", 32'(rx_idx), 0);
    rx_level = 5'd16;
    while (rx_idx < 21) @(negedge clk);
    stop_chan("R12 quiet after rx run");
    total = rx_idx;
    for (int j = 0; j < 8; j++) begin
      k = total - 1 - ((total - 1 - j) % 8);
      check(mem[128 + j] == rx_word(k), "R4 ring slot contents", mem[128 + j], rx_word(k));
    end
    rd(A_DONE, d); check(d == 32'(total / 2), "R9 rx period count", d, 32'(total / 2));

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, fail_cnt);
      $finish;
    end
  end
endmodule